// File: doc/BRIEF.md
# Symmetric Absmax 8-bit Quantizer

This block turns a shard of single-precision values into signed 8-bit codes. It reads the shard twice. During the first pass it keeps the largest magnitude seen. Between the passes it divides a per-format ceiling constant by that magnitude to get a scale factor. During the second pass it multiplies each element by the scale, rounds, clips and packs the codes four to a 32-bit word. The zero point is always 0, so the mapping is symmetric around zero. The same scale register also serves an inverse path, which turns 8-bit codes back into single-precision values by dividing them by the stored factor.

A run begins with a one-cycle `start`. `dq_mode` picks between quantize and dequantize, `tsel` picks the format ceiling, and `in_bf16` marks the input as half-width brain-float. All three are sampled on that cycle. Input and output are valid/ready streams, and `in_last` closes each pass. The input side accepts a beat on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on internal state. It drops while a result word is waiting to be taken and while a dequantize division is running. A word on the output side stays valid, with its data held steady, until `out_ready` takes it. A stalled consumer therefore stalls the input.

Top module: `absq8_quant`

## Requirements
- R1: Pass one tracks the largest magnitude over all elements of the shard, whether they arrive in one burst or several. An element with a zero exponent field counts as zero. Inputs are assumed finite.
- R2: When `in_bf16` was high at start, each element is the 16 bits `in_data[15:0]` placed on top of 16 zero bits. `in_data[31:16]` is ignored. This applies in both passes.
- R3: The scale is the single-precision quotient of the format ceiling divided by the absmax, rounded to nearest-even. The ceiling is 127.0 for `tsel`=0 (signed 8-bit), 30.0 for `tsel`=1 (E4M3 with exponent bias 11) and 57344.0 for `tsel`=2 (E5M2).
- R4: A quantize start with `tsel`=3 raises `err` and keeps it high until the next start. No pass is opened, `in_ready` stays low and `done` stays low.
- R5: Each code is the exact product of element and scale, rounded to the nearest integer with ties going to even.
- R6: Codes clip to the range -127..+127. The value 8'h80 is never produced.
- R7: Element i of a group of four occupies bits [8i+7:8i] of its word, as two's complement. A final partial word has its unused bytes set to zero. `out_last` marks the last word of the pass.
- R8: An absmax of zero gives a scale of zero, and then every code of the second pass is zero.
- R9: In dequantize mode each input code sits in `in_data[7:0]` as two's complement. The output is the single-precision value code / scale, rounded to nearest-even. It is +0 when the code is 0 or the stored scale is 0.
- R10: After reset `out_valid`, `in_ready`, `done` and `err` are low. A held output word keeps its data and last flag stable until it is accepted.
- R11: `done` is high for exactly one cycle, on the cycle after the word carrying `out_last` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the block is idle |
| dq_mode | input | 1 | 0 quantize, 1 dequantize (sampled at start) |
| tsel | input | 2 | Format ceiling select (sampled at start) |
| in_bf16 | input | 1 | Input elements are brain-float in the low half (sampled at start) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 32 | Element or code |
| in_last | input | 1 | Last beat of the current pass |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Packed codes or dequantized value |
| out_last | output | 1 | Last word of the run |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Unsupported format was selected |

## Verification
A wrong absmax or a wrong scale is not visible until the second pass. It then shows up in every code word, which is wrong from the first word onward. It also shows up in a later dequantize run, because that run divides by the stored factor. Rounding and clipping faults appear only on the elements that land on a half-way point or beyond the ceiling, so the stimulus puts exact ties and out-of-range products into the very first words of a pass. A lane or last-flag fault appears on the word where it happens. A handshake fault makes the stream of words and the `done` pulse drift from the cycle-accurate model within one or two cycles.

// File: rtl/absq8_pkg.sv
package absq8_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_PREP, S_DIV, S_QUANT, S_DQIN, S_DQDIV
  } qstate_t;

  // {supported, ceiling as single-precision bits}
  function automatic logic [32:0] type_ceiling(input logic [1:0] sel);
    case (sel)
      2'd0:    return {1'b1, 32'h42FE_0000};  // 127.0
      2'd1:    return {1'b1, 32'h41F0_0000};  // 30.0
      2'd2:    return {1'b1, 32'h4760_0000};  // 57344.0
      default: return {1'b0, 32'h0};
    endcase
  endfunction

endpackage

// File: rtl/absq8_absmax.sv
module absq8_absmax (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [30:0] mag_in,
  output logic [30:0] amax
);
  logic [30:0] mag;

  // zero exponent field counts as zero; magnitudes order like integers
  assign mag = (mag_in[30:23] == 8'd0) ? 31'd0 : mag_in;

  always_ff @(posedge clk) begin
    if (!rst_n)               amax <= '0;
    else if (clr)             amax <= '0;
    else if (en && mag > amax) amax <= mag;
  end
endmodule

// File: rtl/absq8_fdiv.sv
module absq8_fdiv #(
  parameter int STEPS = 27
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] num,
  input  logic [31:0] den,
  output logic        vld,
  output logic [31:0] quo
);
  localparam int CW = $clog2(STEPS);

  logic             run, fin, sg, hi, g, stk;
  logic [CW-1:0]    cnt;
  logic [24:0]      rem;
  logic [23:0]      dm, m;
  logic [24:0]      mr;
  logic [STEPS-1:0] q;
  logic [9:0]       eb, e;

  // quotient bits start at weight 2^0; normalise and round to nearest-even
  always_comb begin
    hi  = q[STEPS-1];
    if (hi) begin
      m   = q[STEPS-1 -: 24];
      g   = q[STEPS-25];
      stk = (|q[STEPS-26:0]) | (|rem);
    end else begin
      m   = q[STEPS-2 -: 24];
      g   = q[STEPS-26];
      stk = (|q[STEPS-27:0]) | (|rem);
    end
    mr = {1'b0, m} + {24'd0, g & (stk | m[0])};
    e  = eb - {9'd0, ~hi} + {9'd0, mr[24]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; fin <= 1'b0; vld <= 1'b0; cnt <= '0; rem <= '0;
      dm <= '0; q <= '0; eb <= '0; sg <= 1'b0; quo <= '0;
    end else begin
      vld <= 1'b0;
      fin <= 1'b0;
      if (go) begin
        run <= 1'b1;
        cnt <= '0;
        rem <= {2'b01, num[22:0]};
        dm  <= {1'b1, den[22:0]};
        q   <= '0;
        eb  <= 10'(num[30:23]) - 10'(den[30:23]) + 10'd127;
        sg  <= num[31] ^ den[31];
      end else if (run) begin
        if (rem >= {1'b0, dm}) begin
          rem <= 25'((rem - {1'b0, dm}) << 1);
          q   <= {q[STEPS-2:0], 1'b1};
        end else begin
          rem <= 25'(rem << 1);
          q   <= {q[STEPS-2:0], 1'b0};
        end
        cnt <= cnt + CW'(1);
        if (cnt == CW'(STEPS - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
      if (fin) begin
        vld <= 1'b1;
        quo <= {sg, e[7:0], mr[24] ? 23'd0 : mr[22:0]};
      end
    end
  end
endmodule

// File: rtl/absq8_enc.sv
module absq8_enc (
  input  logic [31:0] x,
  input  logic [31:0] s,
  output logic [7:0]  code
);
  logic [47:0]        p, ip, mag;
  logic [95:0]        wide;
  logic signed [10:0] sh;
  logic [6:0]         lim;
  logic               g, stk;

  always_comb begin
    p    = {1'b1, x[22:0]} * {1'b1, s[22:0]};
    // value = p * 2^(ex + es - 300)
    sh   = 11'sd300 - $signed({3'b0, x[30:23]}) - $signed({3'b0, s[30:23]});
    wide = {p, 48'd0} >> sh[6:0];
    ip   = wide[95:48];
    g    = wide[47];
    stk  = |wide[46:0];
    mag  = ip + {47'd0, g & (stk | ip[0])};
    if (x[30:23] == 8'd0 || s[30:23] == 8'd0 || sh >= 11'sd49) lim = 7'd0;
    else if (sh <= 11'sd0 || mag > 48'd127)                    lim = 7'd127;
    else                                                        lim = mag[6:0];
    code = (x[31] ^ s[31]) ? (8'd0 - {1'b0, lim}) : {1'b0, lim};
  end
endmodule

// File: rtl/absq8_quant.sv
module absq8_quant #(
  parameter int DIV_STEPS = 27
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        dq_mode,
  input  logic [1:0]  tsel,
  input  logic        in_bf16,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_last,
  output logic        done,
  output logic        err
);
  import absq8_pkg::*;

  localparam int DW     = 32;
  localparam int CODE_W = 8;
  localparam int LANES  = DW / CODE_W;
  localparam int LW     = $clog2(LANES);

  qstate_t       st;
  logic          dq_r, bf_r, ovalid, olast, lpend, acc, div_go, div_vld;
  logic [DW-1:0] fmax_r, scale, cf_r, odata, pack, pack_nx, elem, cf, div_q;
  logic [30:0]   amax;
  logic [7:0]    code, mag8;
  logic [2:0]    lead;
  logic [23:0]   mant;
  logic [32:0]   tm;
  logic [LW-1:0] lane;

  assign tm       = type_ceiling(tsel);
  assign elem     = bf_r ? {in_data[15:0], 16'h0} : in_data;
  assign in_ready = (st == S_SCAN) || ((st == S_QUANT || st == S_DQIN) && !ovalid);
  assign acc      = in_valid && in_ready;

  absq8_absmax u_amax (
    .clk(clk), .rst_n(rst_n), .clr(st == S_IDLE && start),
    .en(acc && st == S_SCAN), .mag_in(elem[30:0]), .amax(amax)
  );

  absq8_fdiv #(.STEPS(DIV_STEPS)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .num(dq_r ? cf_r : fmax_r), .den(dq_r ? scale : {1'b0, amax}),
    .vld(div_vld), .quo(div_q)
  );

  absq8_enc u_enc (.x(elem), .s(scale), .code(code));

  // code byte -> single precision (exact)
  always_comb begin
    mag8 = in_data[7] ? (8'd0 - in_data[7:0]) : in_data[7:0];
    lead = 3'd0;
    for (int i = 0; i < 8; i++) if (mag8[i]) lead = 3'(i);
    mant = {mag8, 16'h0} << (3'd7 - lead);
    cf   = {in_data[7], 8'd127 + {5'd0, lead}, mant[22:0]};
  end

  always_comb begin
    pack_nx = pack;
    pack_nx[lane*CODE_W +: CODE_W] = code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; dq_r <= 1'b0; bf_r <= 1'b0; fmax_r <= '0; scale <= '0;
      cf_r <= '0; pack <= '0; lane <= '0; ovalid <= 1'b0; olast <= 1'b0;
      odata <= '0; lpend <= 1'b0; div_go <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done   <= 1'b0;
      div_go <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          err  <= 1'b0;
          dq_r <= dq_mode;
          bf_r <= in_bf16;
          lane <= '0;
          pack <= '0;
          if (dq_mode)    st <= S_DQIN;
          else if (tm[32]) begin fmax_r <= tm[31:0]; st <= S_SCAN; end
          else            err <= 1'b1;
        end
        S_SCAN: if (acc && in_last) st <= S_PREP;
        S_PREP: if (amax == 31'd0) begin
          scale <= '0;
          st    <= S_QUANT;
        end else begin
          div_go <= 1'b1;
          st     <= S_DIV;
        end
        S_DIV: if (div_vld) begin
          scale <= div_q;
          st    <= S_QUANT;
        end
        S_QUANT: if (acc) begin
          if (lane == LW'(LANES - 1) || in_last) begin
            ovalid <= 1'b1;
            odata  <= pack_nx;
            olast  <= in_last;
            lane   <= '0;
            pack   <= '0;
          end else begin
            lane <= lane + LW'(1);
            pack <= pack_nx;
          end
        end
        S_DQIN: if (acc) begin
          lpend <= in_last;
          if (in_data[7:0] == 8'd0 || scale[30:23] == 8'd0) begin
            ovalid <= 1'b1;
            odata  <= '0;
            olast  <= in_last;
          end else begin
            cf_r   <= cf;
            div_go <= 1'b1;
            st     <= S_DQDIV;
          end
        end
        S_DQDIV: if (div_vld) begin
          ovalid <= 1'b1;
          odata  <= div_q;
          olast  <= lpend;
          st     <= S_DQIN;
        end
        default: st <= S_IDLE;
      endcase
      if (ovalid && out_ready) begin
        ovalid <= 1'b0;
        if (olast) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
      end
    end
  end

  assign out_valid = ovalid;
  assign out_data  = odata;
  assign out_last  = olast;
endmodule

// File: rtl/absq8_quant_chk.sv
module absq8_quant_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        err,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_last,
  input logic [31:0] out_data,
  input logic        dq
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!out_valid && !done));

  // R6
  no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dq) |-> (out_data[7:0] != 8'h80 && out_data[15:8] != 8'h80 &&
                            out_data[23:16] != 8'h80 && out_data[31:24] != 8'h80));
endmodule

bind absq8_quant absq8_quant_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_data(out_data), .dq(dq_r)
);

// File: tb/sim_absq8_quant.sv
module sim_absq8_quant;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, dq_mode = 1'b0, in_bf16 = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [1:0]  tsel = 2'd0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_last, done, err;
  logic [31:0] out_data;

  absq8_quant u0 (.*);

  int nchk = 0, nfail = 0, cyc = 0;
  bit bpm = 1'b0, done_due = 1'b0;
  string cur_req = "R5";
  logic [31:0] expq[$];
  bit lastq[$];
  logic [31:0] scm = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp_v);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp_v);
    end
  endtask

  function automatic logic [31:0] r2f(input real v);
    logic [63:0] b; logic [7:0] e; logic [23:0] m;
    if (v == 0.0) return 32'h0;
    b = $realtobits(v);
    e = 8'(int'(b[62:52]) - 1023 + 127);
    m = {1'b0, b[51:29]} + 24'(b[28] && ((|b[27:0]) || b[29]));
    if (m[23]) begin e = e + 8'd1; m = '0; end
    return {b[63], e, m[22:0]};
  endfunction

  function automatic real f2r(input logic [31:0] x);
    logic [10:0] e;
    if (x[30:23] == 8'd0) return 0.0;
    e = 11'(int'(x[30:23]) - 127 + 1023);
    return $bitstoreal({x[31], e, x[22:0], 29'd0});
  endfunction

  function automatic int rne_sat(input real v);
    real f, d; int i;
    f = $floor(v); d = v - f; i = $rtoi(f);
    if (d > 0.5) i++;
    else if (d == 0.5 && (i % 2) != 0) i++;
    if (i > 127) i = 127;
    if (i < -127) i = -127;
    return i;
  endfunction

  // output monitor: compares every clock against the model queue
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done === done_due, "R11", "done timing", {31'd0, done}, {31'd0, done_due});
      done_due = 1'b0;
      out_ready = bpm ? ((cyc % 3) != 0) : 1'b1;
      cyc++;
      #1;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, cur_req, "unexpected word", out_data, 32'h0);
        else begin
          logic [31:0] ew; bit el;
          ew = expq.pop_front(); el = lastq.pop_front();
          chk(out_data === ew, cur_req, "word", out_data, ew);
          chk(out_last === el, "R7", "last flag", {31'd0, out_last}, {31'd0, el});
          if (out_last) done_due = 1'b1;
        end
      end
    end
  end

  task automatic send(input logic [31:0] d, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic pulse_start(input bit dq, input logic [1:0] ty, input bit bf);
    @(negedge clk);
    start = 1'b1; dq_mode = dq; tsel = ty; in_bf16 = bf;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_q(input logic [1:0] ty, input bit bf, input real vals[$],
                       input bit bp, input string req);
    logic [31:0] xs[$]; logic [31:0] w; real am, tmax, r; int ln, c;
    cur_req = req; bpm = bp;
    am = 0.0;
    foreach (vals[i]) begin
      logic [31:0] f, wb;
      f  = r2f(vals[i]);
      xs.push_back(bf ? {16'hA5C3, f[31:16]} : f);  // R2: upper half is junk
      wb = bf ? {f[31:16], 16'h0} : f;
      r  = f2r(wb);
      if (r < 0.0) r = -r;
      if (r > am) am = r;   // R1 running absmax
    end
    tmax = (ty == 2'd0) ? 127.0 : (ty == 2'd1) ? 30.0 : 57344.0;  // R3
    scm  = (am == 0.0) ? 32'h0 : r2f(tmax / am);                  // R8 when zero
    ln = 0; w = '0;
    foreach (xs[i]) begin
      logic [31:0] wb;
      wb = bf ? {xs[i][15:0], 16'h0} : xs[i];
      c  = (scm == 0) ? 0 : rne_sat(f2r(wb) * f2r(scm));  // R5 R6
      w[ln*8 +: 8] = 8'(c);
      ln++;
      if (ln == 4 || i == xs.size() - 1) begin
        expq.push_back(w); lastq.push_back(i == xs.size() - 1);
        w = '0; ln = 0;
      end
    end
    pulse_start(1'b0, ty, bf);
    #1 chk(err === 1'b0, "R4", "err cleared by start", {31'd0, err}, 32'd0);
    foreach (xs[i]) send(xs[i], i == xs.size() - 1);
    foreach (xs[i]) send(xs[i], i == xs.size() - 1);
    @(posedge done);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, req, "words outstanding", expq.size(), 32'd0);
  endtask

  task automatic run_dq(input int codes[$], input bit bp);
    cur_req = "R9"; bpm = bp;
    foreach (codes[i]) begin
      logic [31:0] ev;
      ev = (codes[i] == 0 || scm == 0) ? 32'h0 : r2f(real'(codes[i]) / f2r(scm));
      expq.push_back(ev); lastq.push_back(i == codes.size() - 1);
    end
    pulse_start(1'b1, 2'd0, 1'b0);
    foreach (codes[i]) send({24'h5A5A5A, 8'(codes[i])}, i == codes.size() - 1);
    @(posedge done);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R9", "words outstanding", expq.size(), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(out_valid === 1'b0, "R10", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk(in_ready === 1'b0, "R10", "reset in_ready", {31'd0, in_ready}, 32'd0);
    chk(done === 1'b0, "R10", "reset done", {31'd0, done}, 32'd0);
    chk(err === 1'b0, "R10", "reset err", {31'd0, err}, 32'd0);

    // R1 R3 R5: int8 ceiling, absmax reached at two signs
    run_q(2'd0, 1'b0, '{1.0, -2.5, 0.75, 3.0, -0.1, 2.9, 0.5, -3.0}, 1'b0, "R1");
    // R5 ties to even, R7 partial word padding, R10 under back-pressure
    run_q(2'd0, 1'b0, '{127.0, 2.5, 3.5, -0.5, 1.5, -127.0}, 1'b1, "R5");
    // R2 widened brain-float, R6 clipping with the E5M2 ceiling
    run_q(2'd2, 1'b1, '{1.0, -0.5, 0.001953125, -0.0009765625, 0.25}, 1'b1, "R6");
    // R3 E4M3 ceiling
    run_q(2'd1, 1'b0, '{2.0, -1.0, 0.1, 0.7, 1.3}, 1'b0, "R3");
    // R9 dequantize against stored scale 15
    run_dq('{0, 15, -30, 127, -128, 1, 7}, 1'b1);
    // R8 all-zero shard
    run_q(2'd0, 1'b0, '{0.0, 0.0, 0.0}, 1'b0, "R8");
    // R9 zero stored scale gives zero values
    run_dq('{5, -9}, 1'b0);

    // R4 unsupported format select
    pulse_start(1'b0, 2'd3, 1'b0);
    #1;
    chk(err === 1'b1, "R4", "err raised", {31'd0, err}, 32'd1);
    chk(in_ready === 1'b0, "R4", "no pass opened", {31'd0, in_ready}, 32'd0);
    repeat (5) @(negedge clk);
    #1;
    chk(err === 1'b1, "R4", "err held", {31'd0, err}, 32'd1);
    chk(in_ready === 1'b0, "R4", "still idle", {31'd0, in_ready}, 32'd0);
    // next start clears err and works
    run_q(2'd0, 1'b0, '{-4.0, 1.0, 2.0, 1.0}, 1'b0, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule